// File: doc/BRIEF.md
# DMA Channel Control and Status Word

This block holds the control and status word of one descriptor-driven DMA channel. A bus decoder hands it 32-bit writes, and the current word is always visible on a read port. Software writes the word to launch a descriptor chain, to acknowledge completion flags and to set the channel's configurable fields. The transfer engine reports back through three inputs: one descriptor block finished, whether that block asked for an interrupt, and the whole chain finished.

A write is handled in a fixed order, with each step seeing the result of the one before:

1. A set reset bit wipes the word and asks the neighbouring descriptor-pointer register to clear.
2. Write-one-to-clear flags are acknowledged.
3. The bits selected by a fixed writable mask are replaced by the written value.

Engine events are applied after the write, so a report from the engine is never lost to a clear that arrives in the same cycle. A launch request goes to the engine only on a 0-to-1 change of the active bit, and only while the engine is idle.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset the status word reads 0, and `start_o`, `irq_o`, `desc_clr_o` and `irq_ack_o` are all 0.
- R2: On a write, the bits selected by mask 0x30FF0001 (bit 0, bits 16 to 23, bits 28 and 29) take the written value. Every other bit keeps its value, and writes to bits 3, 6, 7, 9 to 15 and 24 to 27 have no effect.
- R3: A write that moves the active bit (bit 0) from 0 to 1 while the engine is idle raises `start_o` for exactly one cycle, in the cycle after the write.
- R4: No start is issued when active was already 1 before the write. None is issued while the engine is busy, that is, from one start until the next `chain_done_i`, even if software clears active and sets it again.
- R5: `blk_done_i` sets the end flag (bit 1). Writing 1 to bit 1 clears it, and writing 0 to bit 1 leaves it unchanged.
- R6: `blk_done_i` with `blk_irq_en_i` sets the interrupt flag (bit 2), and `irq_o` follows that flag. Writing 1 to bit 2 clears the flag and drops `irq_o`, and pulses `irq_ack_o` for one cycle so the global interrupt status bit of this channel can be cleared.
- R7: `chain_done_i` clears active and sets the paused-or-idle flag (bit 4). A start clears bit 4.
- R8: Writing 1 to bit 31 clears the whole word before the rest of the write is applied, and pulses `desc_clr_o` for one cycle. Bit 31 always reads 0.
- R9: Writing 1 to bit 30 (abort) has no effect on the word or on the outputs, and bit 30 always reads 0.
- R10: Bits 5 (held by flow control) and 8 (error) always read 0.
- R11: When a write that clears a flag and an engine event that sets the same flag arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe from the bus decoder |
| wr_data_i | input | 32 | Write data |
| blk_done_i | input | 1 | Engine finished one descriptor block |
| blk_irq_en_i | input | 1 | The finished block requests an interrupt |
| chain_done_i | input | 1 | Engine reached the end of the descriptor chain |
| status_o | output | 32 | Current control and status word (read data) |
| start_o | output | 1 | One-cycle launch request to the engine |
| irq_o | output | 1 | Channel interrupt line |
| irq_ack_o | output | 1 | One-cycle request to clear this channel's global interrupt status bit |
| desc_clr_o | output | 1 | One-cycle request to clear the descriptor pointer register |

## Verification
The bench goes after the edge detector with repeated and re-armed active writes while the engine is busy. A level-triggered start would relaunch a running chain on each of these writes. It writes all ones to show the three-step ordering: a merge done before the reset would lose the active bit, and a design without the order would miss the start or the acknowledge. It also lines up a software clear of the end flag with an engine block completion in the same cycle: a design that applied the write last would lose the completion. Finally, it writes into non-writable bits and the abort bit to show those writes change nothing.

// File: rtl/dma_chan_csr_pkg.sv
package dma_chan_csr_pkg;

    // Bit positions that the engine and software both rely on
    localparam int ACT_BIT   = 0;
    localparam int END_BIT   = 1;
    localparam int INT_BIT   = 2;
    localparam int PAUSE_BIT = 4;
    localparam int HELD_BIT  = 5;
    localparam int ERR_BIT   = 8;

    // Launch tracker state
    typedef struct packed {
        logic start;
        logic busy;
    } launch_st_t;

endpackage

// File: rtl/dma_chan_csr_wr.sv
// Applies one software write to the current word: reset, flag clears, masked merge.
module dma_chan_csr_wr #(
    parameter int              WORD_W  = 32,
    parameter logic [WORD_W-1:0] RW_MASK = 32'h30FF_0001
) (
    input  logic [WORD_W-1:0] cur_word_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] merged_o,
    output logic              rst_hit_o,
    output logic              ack_hit_o
);
    import dma_chan_csr_pkg::*;

    localparam int RST_BIT = WORD_W - 1;

    logic [WORD_W-1:0] tmp;

    always_comb begin
        tmp       = cur_word_i;
        rst_hit_o = 1'b0;
        ack_hit_o = 1'b0;
        if (wr_en_i) begin
            if (wr_data_i[RST_BIT]) begin
                tmp       = '0;
                rst_hit_o = 1'b1;
            end
            if (wr_data_i[END_BIT]) begin
                tmp[END_BIT] = 1'b0;
            end
            if (wr_data_i[INT_BIT]) begin
                tmp[INT_BIT] = 1'b0;
                ack_hit_o    = 1'b1;
            end
            tmp = (tmp & ~RW_MASK) | (wr_data_i & RW_MASK);
        end
        merged_o = tmp;
    end

endmodule

// File: rtl/dma_chan_csr_evt.sv
// Folds engine events into the word after the software write has been applied.
module dma_chan_csr_evt #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              launch_i,
    input  logic              blk_done_i,
    input  logic              blk_irq_en_i,
    input  logic              chain_done_i,
    output logic [WORD_W-1:0] word_o
);
    import dma_chan_csr_pkg::*;

    always_comb begin
        word_o = word_i;
        if (launch_i) begin
            word_o[PAUSE_BIT] = 1'b0;
        end
        if (blk_done_i) begin
            word_o[END_BIT] = 1'b1;
            if (blk_irq_en_i) begin
                word_o[INT_BIT] = 1'b1;
            end
        end
        if (chain_done_i) begin
            word_o[ACT_BIT]   = 1'b0;
            word_o[PAUSE_BIT] = 1'b1;
        end
    end

endmodule

// File: rtl/dma_chan_csr_launch.sv
// Edge-detects the active bit and tracks engine occupancy.
module dma_chan_csr_launch (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en_i,
    input  logic old_act_i,
    input  logic new_act_i,
    input  logic chain_done_i,
    output logic launch_o,
    output logic start_o,
    output logic busy_o
);
    import dma_chan_csr_pkg::*;

    launch_st_t st_d, st_q;

    always_comb begin
        launch_o   = wr_en_i && !old_act_i && new_act_i && !st_q.busy;
        st_d.start = launch_o;
        if (chain_done_i) begin
            st_d.busy = 1'b0;
        end else if (launch_o) begin
            st_d.busy = 1'b1;
        end else begin
            st_d.busy = st_q.busy;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o = st_q.start;
    assign busy_o  = st_q.busy;

endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr #(
    parameter int              WORD_W  = 32,
    parameter logic [WORD_W-1:0] RW_MASK = 32'h30FF_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              blk_done_i,
    input  logic              blk_irq_en_i,
    input  logic              chain_done_i,
    output logic [WORD_W-1:0] status_o,
    output logic              start_o,
    output logic              irq_o,
    output logic              irq_ack_o,
    output logic              desc_clr_o
);
    import dma_chan_csr_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              desc_clr;
        logic              irq_ack;
    } csr_st_t;

    csr_st_t st_d, st_q;

    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] evt_word;
    logic              rst_hit;
    logic              ack_hit;
    logic              launch;
    logic              busy;

    dma_chan_csr_wr #(
        .WORD_W (WORD_W),
        .RW_MASK(RW_MASK)
    ) u_wr (
        .cur_word_i(st_q.word),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .merged_o  (merged),
        .rst_hit_o (rst_hit),
        .ack_hit_o (ack_hit)
    );

    dma_chan_csr_launch u_launch (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .old_act_i   (st_q.word[ACT_BIT]),
        .new_act_i   (merged[ACT_BIT]),
        .chain_done_i(chain_done_i),
        .launch_o    (launch),
        .start_o     (start_o),
        .busy_o      (busy)
    );

    dma_chan_csr_evt #(
        .WORD_W(WORD_W)
    ) u_evt (
        .word_i      (merged),
        .launch_i    (launch),
        .blk_done_i  (blk_done_i),
        .blk_irq_en_i(blk_irq_en_i),
        .chain_done_i(chain_done_i),
        .word_o      (evt_word)
    );

    always_comb begin
        st_d.word     = evt_word;
        st_d.desc_clr = rst_hit;
        st_d.irq_ack  = ack_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o   = st_q.word;
    assign irq_o      = st_q.word[INT_BIT];
    assign irq_ack_o  = st_q.irq_ack;
    assign desc_clr_o = st_q.desc_clr;

    logic unused_busy;
    assign unused_busy = busy;

endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en_i,
    input logic [31:0] wr_data_i,
    input logic        blk_done_i,
    input logic        blk_irq_en_i,
    input logic        chain_done_i,
    input logic [31:0] status_o,
    input logic        start_o,
    input logic        irq_o,
    input logic        desc_clr_o
);

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R4
    start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(!status_o[0] && wr_en_i && wr_data_i[0]));

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(blk_done_i && blk_irq_en_i));

    // R7
    chain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chain_done_i) |-> (!status_o[0] && status_o[4]));

    // R8
    desc_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_clr_o |-> $past(wr_en_i && wr_data_i[31]));

    // R10
    dead_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[5] == 1'b0) && (status_o[8] == 1'b0) && (status_o[31:30] == 2'b00));

endmodule

bind dma_chan_csr dma_chan_csr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .blk_done_i  (blk_done_i),
    .blk_irq_en_i(blk_irq_en_i),
    .chain_done_i(chain_done_i),
    .status_o    (status_o),
    .start_o     (start_o),
    .irq_o       (irq_o),
    .desc_clr_o  (desc_clr_o)
);

// File: tb/tb_dma_chan_csr.sv
module tb_dma_chan_csr;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        blk_done_i = 1'b0;
    logic        blk_irq_en_i = 1'b0;
    logic        chain_done_i = 1'b0;
    logic [31:0] status_o;
    logic        start_o;
    logic        irq_o;
    logic        irq_ack_o;
    logic        desc_clr_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_csr dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .blk_done_i  (blk_done_i),
        .blk_irq_en_i(blk_irq_en_i),
        .chain_done_i(chain_done_i),
        .status_o    (status_o),
        .start_o     (start_o),
        .irq_o       (irq_o),
        .irq_ack_o   (irq_ack_o),
        .desc_clr_o  (desc_clr_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // One-cycle write; returns at the following falling edge, where outputs show the result
    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_data_i = d;
        @(negedge clk);
        wr_en_i   = 1'b0;
        wr_data_i = '0;
    endtask

    task automatic ev(input logic blk, input logic ien, input logic chn);
        @(negedge clk);
        blk_done_i   = blk;
        blk_irq_en_i = ien;
        chain_done_i = chn;
        @(negedge clk);
        blk_done_i   = 1'b0;
        blk_irq_en_i = 1'b0;
        chain_done_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 status", status_o, 32'h0);
        check("R1 start", {31'b0, start_o}, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 pulses", {30'b0, irq_ack_o, desc_clr_o}, 32'h0);
    endtask

    task automatic t_mask();
        wr(32'h30FF_0000);
        check("R2 merge", status_o, 32'h30FF_0000);
        check("R2 no start", {31'b0, start_o}, 32'h0);
        wr(32'h0F00_FFC8);
        check("R2 non-writable ignored", status_o, 32'h0);
    endtask

    task automatic t_start();
        wr(32'h1);
        check("R3 start pulse", {31'b0, start_o}, 32'h1);
        check("R3 status active", status_o, 32'h1);
        @(negedge clk);
        check("R3 pulse one cycle", {31'b0, start_o}, 32'h0);
    endtask

    task automatic t_nostart();
        wr(32'h1);
        check("R4 already active", {31'b0, start_o}, 32'h0);
        wr(32'h0);
        check("R4 active cleared by write", status_o, 32'h0);
        wr(32'h1);
        check("R4 busy re-arm ignored", {31'b0, start_o}, 32'h0);
        ev(1'b0, 1'b0, 1'b1);
        check("R7 chain end", status_o, 32'h10);
        wr(32'h1);
        check("R3 restart after chain", {31'b0, start_o}, 32'h1);
        check("R7 paused cleared on start", status_o, 32'h1);
    endtask

    task automatic t_end();
        ev(1'b1, 1'b0, 1'b0);
        check("R5 end set", status_o, 32'h3);
        check("R6 no irq without enable", {31'b0, irq_o}, 32'h0);
        wr(32'h1);
        check("R5 write 0 keeps end", status_o, 32'h3);
        wr(32'h3);
        check("R5 write 1 clears end", status_o, 32'h1);
    endtask

    task automatic t_int();
        ev(1'b1, 1'b1, 1'b0);
        check("R6 int set", status_o, 32'h7);
        check("R6 irq high", {31'b0, irq_o}, 32'h1);
        wr(32'h5);
        check("R6 int cleared", status_o, 32'h3);
        check("R6 irq low", {31'b0, irq_o}, 32'h0);
        check("R6 ack pulse", {31'b0, irq_ack_o}, 32'h1);
        @(negedge clk);
        check("R6 ack one cycle", {31'b0, irq_ack_o}, 32'h0);
        wr(32'h3);
        ev(1'b0, 1'b0, 1'b1);
        check("R7 chain end again", status_o, 32'h10);
    endtask

    task automatic t_rstbit();
        wr(32'h00AB_0000);
        check("R2 fields keep paused", status_o, 32'h00AB_0010);
        ev(1'b1, 1'b1, 1'b0);
        check("R6 flags before reset", status_o, 32'h00AB_0016);
        wr(32'h8000_0000);
        check("R8 word cleared", status_o, 32'h0);
        check("R8 desc clear pulse", {31'b0, desc_clr_o}, 32'h1);
        check("R8 irq dropped", {31'b0, irq_o}, 32'h0);
        check("R8 no ack", {31'b0, irq_ack_o}, 32'h0);
    endtask

    task automatic t_abort();
        wr(32'h1);
        check("R3 start after reset", {31'b0, start_o}, 32'h1);
        wr(32'h4000_0001);
        check("R9 abort no effect", status_o, 32'h1);
        check("R9 no start/clear", {30'b0, start_o, desc_clr_o}, 32'h0);
        ev(1'b0, 1'b0, 1'b1);
        check("R9 chain still ends", status_o, 32'h10);
    endtask

    task automatic t_allones();
        ev(1'b1, 1'b1, 1'b0);
        wr(32'hFFFF_FFFF);
        check("R10 all ones", status_o, 32'h30FF_0001);
        check("R8 ordered start", {31'b0, start_o}, 32'h1);
        check("R8 ordered pulses", {30'b0, irq_ack_o, desc_clr_o}, 32'h3);
        ev(1'b0, 1'b0, 1'b1);
        check("R10 after chain", status_o, 32'h30FF_0010);
    endtask

    task automatic t_collide();
        ev(1'b1, 1'b0, 1'b0);
        check("R11 setup", status_o, 32'h30FF_0012);
        @(negedge clk);
        wr_en_i    = 1'b1;
        wr_data_i  = 32'h30FF_0002;
        blk_done_i = 1'b1;
        @(negedge clk);
        wr_en_i    = 1'b0;
        wr_data_i  = '0;
        blk_done_i = 1'b0;
        check("R11 event wins", status_o, 32'h30FF_0012);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_start();
        t_nostart();
        t_end();
        t_int();
        t_rstbit();
        t_abort();
        t_allones();
        t_collide();
        finished = 1'b1;
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

endmodule